// File: doc/BRIEF.md
# Multicore Doorbell Message Router

This block carries doorbell messages between the cores of a small cluster. In any cycle each core may present one command: a send or a clear, with a 32-bit message word. A send turns on a pending doorbell of the class named in the word on every core it addresses. A core is addressed when its processor ID matches the tag in the word, or on every core when the broadcast flag is set. A clear drops the pending bit of the named class on the issuing core and on no other core.

Each core has two pending outputs, one for normal doorbells and one for critical doorbells. A pending bit stays set until the owning core clears it or the core's interrupt controller acknowledges it. Only supervisor-mode commands take effect. A command issued in user mode is dropped and raises a one-cycle fault pulse back to the issuing core.

Top module: `doorbell_router`

## Requirements
- R1: The class sits in word bits 31:27. Code 0 selects the normal doorbell and code 1 selects the critical doorbell. A send from a supervisor-mode command sets the pending bit of that class on each addressed core at the clock edge where the command is sampled, so the bit is visible in the following cycle.
- R2: Class codes 2, 3 and 4 (guest normal, guest critical, guest machine-check), and every other code except 0 and 1, are accepted without any change to pending state, for both send and clear.
- R3: When bit 26 (broadcast) of a send is set, every core is addressed whatever its processor ID.
- R4: When bit 26 is clear, a send addresses only the cores whose `core_id_i` slice equals word bits 13:0 over all 14 bits. All other cores are left unchanged.
- R5: Word bits 25:14 (partition tag) have no effect on routing or on any state.
- R6: A clear drops the pending bit of its decoded class on the issuing core only. Tag and broadcast bits are ignored for a clear.
- R7: A command with `cmd_user_i` high changes no pending state. It drives `priv_fault_o` of the issuing core high for exactly the next cycle.
- R8: If a set and a drop (clear or acknowledge) reach the same pending bit in the same cycle, the bit ends up set.
- R9: `ack_norm_i[i]` / `ack_crit_i[i]` drop the matching pending bit of core i. With no set, clear or acknowledge, a pending bit holds its value.
- R10: Reset (`rst_ni` low) clears all pending bits and all fault outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | NUM_CORES | Command present, one bit per core |
| cmd_clr_i | input | NUM_CORES | 1 = clear, 0 = send |
| cmd_user_i | input | NUM_CORES | Issuing core is in user mode |
| cmd_word_i | input | NUM_CORES*32 | Message word per core, core i at bits 32*i+31:32*i |
| core_id_i | input | NUM_CORES*14 | Processor ID of each core |
| ack_norm_i | input | NUM_CORES | Acknowledge of normal doorbell |
| ack_crit_i | input | NUM_CORES | Acknowledge of critical doorbell |
| pend_norm_o | output | NUM_CORES | Normal doorbell pending |
| pend_crit_o | output | NUM_CORES | Critical doorbell pending |
| priv_fault_o | output | NUM_CORES | Privileged-instruction fault pulse |

## Verification
The bench builds the router with NUM_CORES = 4 and four distinct 14-bit IDs. One ID has bit 13 set and another differs from it only in that bit, so a comparison that drops tag bits becomes visible. With four cores the bench can exercise several sources sending in one cycle, a broadcast reaching a core whose ID is not in the tag, and one core's clear racing another core's send to the same bit. A behavioural model predicts every pending and fault output, and the bench compares them every cycle.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int MSG_W     = 32;
  localparam int CLASS_W   = 5;
  localparam int CLASS_LSB = 27;
  localparam int BCAST_BIT = 26;
  localparam int PART_LSB  = 14;
  localparam int PART_MSB  = 25;
  localparam int TAG_W     = 14;

  typedef enum logic [CLASS_W-1:0] {
    CLS_NORM  = 5'd0,
    CLS_CRIT  = 5'd1,
    CLS_GNORM = 5'd2,
    CLS_GCRIT = 5'd3,
    CLS_GMCHK = 5'd4
  } db_class_e;

  typedef struct packed {
    logic             send;
    logic             clr;
    logic             norm;
    logic             crit;
    logic             bcast;
    logic [TAG_W-1:0] tag;
  } db_cmd_t;
endpackage

// File: rtl/db_decode.sv
module db_decode
  import doorbell_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             clr_i,
  input  logic             user_i,
  input  logic [MSG_W-1:0] word_i,
  output db_cmd_t          cmd_o,
  output logic             fault_o
);
  logic [CLASS_W-1:0] cls;
  logic               legal;
  logic               fault_q;
  logic               unused_part;

  assign cls         = word_i[CLASS_LSB +: CLASS_W];
  assign legal       = valid_i && !user_i;
  assign unused_part = ^word_i[PART_MSB:PART_LSB];

  always_comb begin
    cmd_o.send  = legal && !clr_i;
    cmd_o.clr   = legal && clr_i;
    // guest classes and unknown codes decode to no class at all
    cmd_o.norm  = (cls == CLS_NORM);
    cmd_o.crit  = (cls == CLS_CRIT);
    cmd_o.bcast = word_i[BCAST_BIT];
    cmd_o.tag   = word_i[TAG_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= valid_i && user_i;
  end
  assign fault_o = fault_q;

  AST_USER_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_i |-> !cmd_o.send && !cmd_o.clr);                        // R7
  AST_FAULT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && user_i |=> fault_o);                               // R7
  AST_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && user_i) |=> !fault_o);                           // R7
endmodule

// File: rtl/db_match.sv
module db_match
  import doorbell_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  db_cmd_t          cmd_i [NUM_CORES],
  input  logic [TAG_W-1:0] my_id_i,
  output logic             set_norm_o,
  output logic             set_crit_o
);
  logic [NUM_CORES-1:0] hit;
  logic [NUM_CORES-1:0] unused_clr;

  always_comb begin
    set_norm_o = 1'b0;
    set_crit_o = 1'b0;
    for (int s = 0; s < NUM_CORES; s++) begin
      hit[s]        = cmd_i[s].send && (cmd_i[s].bcast || cmd_i[s].tag == my_id_i);
      unused_clr[s] = cmd_i[s].clr;
      set_norm_o    = set_norm_o | (hit[s] && cmd_i[s].norm);
      set_crit_o    = set_crit_o | (hit[s] && cmd_i[s].crit);
    end
  end
endmodule

// File: rtl/db_pend_bit.sv
module db_pend_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;  // a new doorbell beats any drop
    else if (clr_i || ack_i) pend_q <= 1'b0;
  end
  assign pend_o = pend_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);                                            // R8
  AST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && (clr_i || ack_i) |=> !pend_o);                      // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i && !ack_i |=> pend_o == $past(pend_o));      // R9
endmodule

// File: rtl/doorbell_router.sv
module doorbell_router
  import doorbell_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CORES-1:0]       cmd_valid_i,
  input  logic [NUM_CORES-1:0]       cmd_clr_i,
  input  logic [NUM_CORES-1:0]       cmd_user_i,
  input  logic [NUM_CORES*MSG_W-1:0] cmd_word_i,
  input  logic [NUM_CORES*TAG_W-1:0] core_id_i,
  input  logic [NUM_CORES-1:0]       ack_norm_i,
  input  logic [NUM_CORES-1:0]       ack_crit_i,
  output logic [NUM_CORES-1:0]       pend_norm_o,
  output logic [NUM_CORES-1:0]       pend_crit_o,
  output logic [NUM_CORES-1:0]       priv_fault_o
);
  db_cmd_t              cmd [NUM_CORES];
  logic [NUM_CORES-1:0] set_norm, set_crit;
  logic [NUM_CORES-1:0] clr_norm, clr_crit;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    db_decode u_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (cmd_valid_i[g]),
      .clr_i   (cmd_clr_i[g]),
      .user_i  (cmd_user_i[g]),
      .word_i  (cmd_word_i[g*MSG_W +: MSG_W]),
      .cmd_o   (cmd[g]),
      .fault_o (priv_fault_o[g])
    );

    db_match #(.NUM_CORES(NUM_CORES)) u_match (
      .cmd_i      (cmd),
      .my_id_i    (core_id_i[g*TAG_W +: TAG_W]),
      .set_norm_o (set_norm[g]),
      .set_crit_o (set_crit[g])
    );

    // clear acts on the issuing core only
    assign clr_norm[g] = cmd[g].clr && cmd[g].norm;
    assign clr_crit[g] = cmd[g].clr && cmd[g].crit;

    db_pend_bit u_norm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_norm[g]),
      .clr_i  (clr_norm[g]),
      .ack_i  (ack_norm_i[g]),
      .pend_o (pend_norm_o[g])
    );

    db_pend_bit u_crit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_crit[g]),
      .clr_i  (clr_crit[g]),
      .ack_i  (ack_crit_i[g]),
      .pend_o (pend_crit_o[g])
    );

    AST_BCAST_REACH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_valid_i[g] && !cmd_clr_i[g] && !cmd_user_i[g] &&
      cmd_word_i[g*MSG_W+BCAST_BIT] &&
      cmd_word_i[g*MSG_W+CLASS_LSB +: CLASS_W] == CLS_CRIT
      |=> &pend_crit_o);                                          // R3
  end

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |((pend_norm_o | pend_crit_o) & ~$past(pend_norm_o | pend_crit_o))
    |-> $past(|(cmd_valid_i & ~cmd_user_i & ~cmd_clr_i)));         // R2
endmodule

// File: tb/doorbell_router_tb.sv
module doorbell_router_tb_top;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   valid, clr, user, ack_n, ack_c;
  logic [31:0]    word [N];
  logic [13:0]    id   [N];
  logic [N*32-1:0] word_flat;
  logic [N*14-1:0] id_flat;
  logic [N-1:0]   pend_n, pend_c, fault;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit [N-1:0] m_n, m_c, m_f;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      word_flat[i*32 +: 32] = word[i];
      id_flat[i*14 +: 14]   = id[i];
    end
  end

  doorbell_router #(.NUM_CORES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(valid), .cmd_clr_i(clr), .cmd_user_i(user),
    .cmd_word_i(word_flat), .core_id_i(id_flat),
    .ack_norm_i(ack_n), .ack_crit_i(ack_c),
    .pend_norm_o(pend_n), .pend_crit_o(pend_c), .priv_fault_o(fault)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n = '0; m_c = '0; m_f = '0;
    end else begin
      bit [N-1:0] sn, sc, cn, cc;
      sn = '0; sc = '0; cn = '0; cc = '0;
      for (int t = 0; t < N; t++) begin
        for (int s = 0; s < N; s++) begin
          if (valid[s] && !user[s] && !clr[s] &&
              (word[s][26] || word[s][13:0] == id[t])) begin
            if (word[s][31:27] == 5'd0) sn[t] = 1'b1;
            if (word[s][31:27] == 5'd1) sc[t] = 1'b1;
          end
        end
        if (valid[t] && !user[t] && clr[t]) begin
          if (word[t][31:27] == 5'd0) cn[t] = 1'b1;
          if (word[t][31:27] == 5'd1) cc[t] = 1'b1;
        end
      end
      m_n = sn | (m_n & ~cn & ~ack_n);
      m_c = sc | (m_c & ~cc & ~ack_c);
      m_f = valid & user;
    end
  end

  function automatic logic [31:0] mk(input int cls, input bit bc,
                                     input logic [11:0] part, input logic [13:0] tag);
    return {cls[4:0], bc, part, tag};
  endfunction

  task automatic compare(input string req);
    for (int t = 0; t < N; t++) begin
      total += 3;
      if (pend_n[t] !== m_n[t]) begin
        bad++; $display("FAIL %s core%0d pend_norm actual=%b expected=%b", req, t, pend_n[t], m_n[t]);
      end
      if (pend_c[t] !== m_c[t]) begin
        bad++; $display("FAIL %s core%0d pend_crit actual=%b expected=%b", req, t, pend_c[t], m_c[t]);
      end
      if (fault[t] !== m_f[t]) begin
        bad++; $display("FAIL %s core%0d priv_fault actual=%b expected=%b", req, t, fault[t], m_f[t]);
      end
    end
  endtask

  task automatic expect_bits(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++; $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    valid = '0; clr = '0; user = '0; ack_n = '0; ack_c = '0;
    for (int i = 0; i < N; i++) word[i] = '0;
  endtask

  task automatic tick(input string req);
    @(posedge clk); #2;
    compare(req);
    idle();
  endtask

  task automatic cmd(input int c, input bit is_clr, input bit is_user, input logic [31:0] w);
    valid[c] = 1'b1; clr[c] = is_clr; user[c] = is_user; word[c] = w;
  endtask

  initial begin
    id[0] = 14'h0011; id[1] = 14'h0022; id[2] = 14'h2005; id[3] = 14'h0005;
    idle();
    repeat (3) @(posedge clk);
    #2;
    compare("R10");
    expect_bits("R10 reset pending", pend_n | pend_c, '0);
    rst_n = 1'b1;
    tick("R10");

    // R1/R4: normal doorbell to core2 only (tag differs from core3 in bit 13)
    cmd(0, 0, 0, mk(0, 0, 12'h000, 14'h2005));
    tick("R4");
    expect_bits("R1 R4 normal to core2", pend_n, 4'b0100);

    // R1: critical doorbell to core3
    cmd(1, 0, 0, mk(1, 0, 12'h000, 14'h0005));
    tick("R1");
    expect_bits("R1 critical to core3", pend_c, 4'b1000);

    // R3: broadcast critical, tag matches nobody
    cmd(2, 0, 0, mk(1, 1, 12'h000, 14'h3FFF));
    tick("R3");
    expect_bits("R3 broadcast critical", pend_c, 4'b1111);

    // R6: core1 clears critical, tag aimed at core0 and broadcast set
    cmd(1, 1, 0, mk(1, 1, 12'h000, 14'h0011));
    tick("R6");
    expect_bits("R6 clear own core only", pend_c, 4'b1101);

    // R2: guest and unknown classes, send and clear
    cmd(0, 0, 0, mk(2, 1, 12'h000, 14'h0));
    cmd(1, 0, 0, mk(3, 1, 12'h000, 14'h0));
    cmd(2, 0, 0, mk(4, 1, 12'h000, 14'h0));
    cmd(3, 1, 0, mk(31, 0, 12'h000, 14'h0));
    tick("R2");
    expect_bits("R2 guest sends no effect norm", pend_n, 4'b0100);
    expect_bits("R2 guest sends no effect crit", pend_c, 4'b1101);
    cmd(2, 1, 0, mk(2, 0, 12'h000, 14'h0));
    cmd(3, 1, 0, mk(4, 0, 12'h000, 14'h0));
    tick("R2");
    expect_bits("R2 guest clear no effect", pend_c, 4'b1101);

    // R5: partition tag nonzero, routing unchanged
    cmd(3, 0, 0, mk(0, 0, 12'hABC, 14'h0022));
    tick("R5");
    expect_bits("R5 partition ignored", pend_n, 4'b0110);

    // R7: user-mode send and clear
    cmd(0, 0, 1, mk(0, 1, 12'h000, 14'h0));
    cmd(2, 1, 1, mk(0, 0, 12'h000, 14'h0));
    tick("R7");
    expect_bits("R7 user no state", pend_n, 4'b0110);
    expect_bits("R7 fault pulse", fault, 4'b0101);
    tick("R7");
    expect_bits("R7 fault one cycle", fault, 4'b0000);

    // R8: core3 clears norm while core0 sends norm to core3; ack racing send
    cmd(3, 1, 0, mk(0, 0, 12'h000, 14'h0));
    tick("R8");
    cmd(0, 0, 0, mk(0, 0, 12'h000, 14'h0005));
    cmd(3, 1, 0, mk(0, 0, 12'h000, 14'h0));
    ack_c[0] = 1'b1;
    cmd(1, 0, 0, mk(1, 0, 12'h000, 14'h0011));
    tick("R8");
    expect_bits("R8 send beats clear", pend_n[3], 1'b1);
    expect_bits("R8 send beats ack", pend_c[0], 1'b1);

    // R9: acknowledges and hold
    ack_n = 4'b1010; ack_c = 4'b0001;
    tick("R9");
    expect_bits("R9 ack norm", pend_n, 4'b0100);
    expect_bits("R9 ack crit", pend_c, 4'b1100);
    repeat (3) tick("R9");
    expect_bits("R9 hold", pend_c, 4'b1100);

    // multiple sources in one cycle
    cmd(0, 0, 0, mk(0, 0, 12'h000, 14'h0011));
    cmd(1, 0, 0, mk(0, 0, 12'h000, 14'h0005));
    cmd(2, 0, 0, mk(1, 0, 12'h000, 14'h0022));
    tick("R1");

    // R10: reset mid-run
    rst_n = 1'b0;
    #1;
    compare("R10");
    expect_bits("R10 async reset", pend_n | pend_c | fault, '0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    tick("R10");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule